// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits on the sample path of a data converter, just ahead of the output pins. A 4-bit test code selects either normal operation, where each incoming sample passes through untouched, or one of a set of synthetic patterns. The patterns are fixed levels, alternating words, a walking bit, a one-shot sync word, two user words and two pseudo-random sequences. Each pattern word replaces the live sample on every cycle that carries a valid sample, so a receiver can check lane wiring, bit order and framing before real data flows.

Each pseudo-random generator has its own reload control, so a receiver can re-align to the start of either sequence without disturbing the other. Samples are 14-bit offset binary. Output data and its valid flag are registered with one cycle of latency. The pattern state restarts whenever the test code or the user-pattern mode changes.

Top module: `conv_tpg`

## Requirements
- R1: While `rst_n` is low, `smp_out` is 0 and `smp_out_vld` is 0.
- R2: `smp_out_vld` equals `smp_valid` of the previous cycle. `smp_out` takes a new value only after a cycle with `smp_valid` high, and holds its value otherwise.
- R3: Code 0 forwards `smp_in` unchanged. Code 1 gives 0x2000, code 2 gives 0x3FFF and code 3 gives 0x0000.
- R4: Code 4 alternates 0x2AAA and 0x1555, starting with 0x2AAA. Code 7 alternates 0x3FFF and 0x0000, starting with 0x3FFF. Each valid sample counts as one step.
- R5: Code 9 alternates 0x0001 and 0x0000, starting with 0x0001. Code 11 outputs a single set bit that starts at bit 0, moves up one position per valid sample, and returns to bit 0 after bit 13.
- R6: Code 10 outputs 0x3FFF on the first valid sample after the pattern restarts and 0x0000 on every later sample.
- R7: Code 8 uses the user-pattern mode `user_mode`. Value 0 repeats `user_word1`. Value 1 alternates `user_word1` then `user_word2`. Value 2 emits `user_word1` once and then 0x0000. Value 3 emits `user_word1` and then `user_word2` once each, followed by 0x0000.
- R8: Code 6 is a 9-bit generator for x^9+x^5+1 with seed all ones. Each step forms bit b = s[8] XOR s[4] and shifts s left, inserting b. Fourteen steps run per valid sample, and the bits produced fill the word from bit 13 down to bit 0.
- R9: Code 5 is the same scheme with a 23-bit register for x^23+x^18+1 (b = s[22] XOR s[17]) and seed all ones.
- R10: `pn_long_rst` reloads the 23-bit seed and `pn_short_rst` reloads the 9-bit seed. A valid sample in the same cycle uses the reloaded seed. Neither control affects the other generator.
- R11: A change of `mode_code` or `user_mode` restarts all pattern state, including both generator seeds. The next valid sample shows the first word of the new pattern.
- R12: Codes 12 to 15 output 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 4 | Test pattern code |
| user_mode | input | 2 | User pattern repeat/once selection |
| user_word1 | input | 14 | First user pattern word |
| user_word2 | input | 14 | Second user pattern word |
| pn_long_rst | input | 1 | Reload the 23-bit generator seed |
| pn_short_rst | input | 1 | Reload the 9-bit generator seed |
| smp_valid | input | 1 | Input sample valid strobe |
| smp_in | input | 14 | Normal converter sample |
| smp_out | output | 14 | Output sample, offset binary |
| smp_out_vld | output | 1 | Output sample valid |

## Verification
Normal data is fed with distinct values and idle gaps between samples. These gaps separate a correct pass-through from an output that is stuck, or one that updates on invalid cycles. Each alternating and walking pattern runs long enough to wrap, and is interrupted by idle cycles, which shows the state advancing only on valid samples. Both generators run for many words, and each reload is pulsed while the other generator is active, so reseeding the wrong register shows up. The test code and user mode are changed in the middle of a pattern and then restored, which shows whether the pattern restarts or resumes.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [3:0] {
    TM_OFF      = 4'd0,
    TM_MID      = 4'd1,
    TM_POS_FS   = 4'd2,
    TM_NEG_FS   = 4'd3,
    TM_CHECKER  = 4'd4,
    TM_PN_LONG  = 4'd5,
    TM_PN_SHORT = 4'd6,
    TM_WORD_TGL = 4'd7,
    TM_USER     = 4'd8,
    TM_BIT_TGL  = 4'd9,
    TM_SYNC     = 4'd10,
    TM_ONE_HOT  = 4'd11,
    TM_MIXED    = 4'd12
  } tpg_mode_e;

  typedef enum logic [1:0] {
    UP_SINGLE      = 2'd0,
    UP_ALT         = 2'd1,
    UP_SINGLE_ONCE = 2'd2,
    UP_ALT_ONCE    = 2'd3
  } tpg_user_e;
endpackage

// File: rtl/tpg_pn_gen.sv
// Fibonacci LFSR that yields W bits per step, first bit in the MSB.
module tpg_pn_gen #(
  parameter int LEN = 9,
  parameter int TAP = 5,
  parameter int W   = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic         step,
  output logic [W-1:0] word
);
  logic [LEN-1:0] st_q, st_d, st_eff, st_adv;

  always_comb begin
    logic fb;
    fb     = 1'b0;
    st_eff = reload ? '1 : st_q;
    st_adv = st_eff;
    word   = '0;
    for (int i = 0; i < W; i++) begin
      fb            = st_adv[LEN-1] ^ st_adv[TAP-1];
      word[W-1-i]   = fb;
      st_adv        = {st_adv[LEN-2:0], fb};
    end
    st_d = step ? st_adv : st_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '1;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/tpg_seq_state.sv
// Shared pattern sequencing: phase toggle, walking index, saturating count.
module tpg_seq_state #(
  parameter int W  = 14,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  output logic          phase,
  output logic [IW-1:0] walk,
  output logic [1:0]    cnt
);
  localparam logic [IW-1:0] WALK_LAST = IW'(W - 1);

  logic          phase_q, phase_d;
  logic [IW-1:0] walk_q, walk_d;
  logic [1:0]    cnt_q, cnt_d;

  always_comb begin
    phase = restart ? 1'b0 : phase_q;
    walk  = restart ? '0   : walk_q;
    cnt   = restart ? 2'd0 : cnt_q;
    phase_d = phase;
    walk_d  = walk;
    cnt_d   = cnt;
    if (step) begin
      phase_d = ~phase;
      walk_d  = (walk == WALK_LAST) ? '0 : walk + 1'b1;
      cnt_d   = (cnt == 2'd2) ? cnt : cnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      walk_q  <= '0;
      cnt_q   <= 2'd0;
    end else begin
      phase_q <= phase_d;
      walk_q  <= walk_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/conv_tpg.sv
module conv_tpg
  import tpg_pkg::*;
#(
  parameter int W         = 14,
  parameter int PNL_LEN   = 23,
  parameter int PNL_TAP   = 18,
  parameter int PNS_LEN   = 9,
  parameter int PNS_TAP   = 5,
  localparam int IW       = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode_code,
  input  logic [1:0]   user_mode,
  input  logic [W-1:0] user_word1,
  input  logic [W-1:0] user_word2,
  input  logic         pn_long_rst,
  input  logic         pn_short_rst,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_in,
  output logic [W-1:0] smp_out,
  output logic         smp_out_vld
);
  localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] FULL     = '1;

  logic [3:0]    mode_prev_q;
  logic [1:0]    umode_prev_q;
  logic          restart;
  logic          phase;
  logic [IW-1:0] walk;
  logic [1:0]    cnt;
  logic [W-1:0]  pnl_word, pns_word;
  logic [W-1:0]  chk_a;
  logic [W-1:0]  user_val;
  logic [W-1:0]  pat;
  logic [W-1:0]  out_q;
  logic          vld_q;

  assign restart = (mode_code != mode_prev_q) || (user_mode != umode_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_prev_q  <= 4'd0;
      umode_prev_q <= 2'd0;
    end else begin
      mode_prev_q  <= mode_code;
      umode_prev_q <= user_mode;
    end
  end

  tpg_seq_state #(.W(W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (smp_valid),
    .phase   (phase),
    .walk    (walk),
    .cnt     (cnt)
  );

  tpg_pn_gen #(.LEN(PNL_LEN), .TAP(PNL_TAP), .W(W)) u_pn_long (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (pn_long_rst | restart),
    .step   (smp_valid && (mode_code == TM_PN_LONG)),
    .word   (pnl_word)
  );

  tpg_pn_gen #(.LEN(PNS_LEN), .TAP(PNS_TAP), .W(W)) u_pn_short (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (pn_short_rst | restart),
    .step   (smp_valid && (mode_code == TM_PN_SHORT)),
    .word   (pns_word)
  );

  // Checkerboard: odd bit positions set in the first word.
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_chk
      assign chk_a[gi] = (gi % 2) == 1;
    end
  endgenerate

  always_comb begin
    case (user_mode)
      UP_SINGLE:      user_val = user_word1;
      UP_ALT:         user_val = phase ? user_word2 : user_word1;
      UP_SINGLE_ONCE: user_val = (cnt == 2'd0) ? user_word1 : '0;
      default:        user_val = (cnt == 2'd0) ? user_word1 :
                                 (cnt == 2'd1) ? user_word2 : '0;
    endcase
  end

  always_comb begin
    case (mode_code)
      TM_OFF:      pat = smp_in;
      TM_MID:      pat = MIDSCALE;
      TM_POS_FS:   pat = FULL;
      TM_NEG_FS:   pat = '0;
      TM_CHECKER:  pat = phase ? ~chk_a : chk_a;
      TM_PN_LONG:  pat = pnl_word;
      TM_PN_SHORT: pat = pns_word;
      TM_WORD_TGL: pat = phase ? '0 : FULL;
      TM_USER:     pat = user_val;
      TM_BIT_TGL:  pat = phase ? '0 : W'(1);
      TM_SYNC:     pat = (cnt == 2'd0) ? FULL : '0;
      TM_ONE_HOT:  pat = W'(1) << walk;
      default:     pat = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_valid;
      if (smp_valid) out_q <= pat;
    end
  end

  assign smp_out     = out_q;
  assign smp_out_vld = vld_q;
endmodule

// File: rtl/conv_tpg_chk.sv
module conv_tpg_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   mode_code,
  input logic         smp_valid,
  input logic [W-1:0] smp_in,
  input logic [W-1:0] smp_out,
  input logic         smp_out_vld
);
  assert_vld_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> smp_out_vld);

  assert_vld_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !smp_out_vld);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(smp_out));

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_code == 4'd0) |=> smp_out == $past(smp_in));

  assert_midscale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_code == 4'd1) |=> smp_out == {1'b1, {(W-1){1'b0}}});

  assert_walk_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_code == 4'd11) |=> $countones(smp_out) == 1);

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_code >= 4'd12) |=> smp_out == '0);
endmodule

bind conv_tpg conv_tpg_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_code   (mode_code),
  .smp_valid   (smp_valid),
  .smp_in      (smp_in),
  .smp_out     (smp_out),
  .smp_out_vld (smp_out_vld)
);

// File: tb/conv_tpg_test.sv
`timescale 1ns/1ps
module conv_tpg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mode_code;
  logic [1:0]  user_mode;
  logic [13:0] user_word1, user_word2;
  logic        pn_long_rst, pn_short_rst;
  logic        smp_valid;
  logic [13:0] smp_in;
  logic [13:0] smp_out;
  logic        smp_out_vld;

  always #2.5 clk = ~clk;

  conv_tpg uut (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .user_mode(user_mode),
    .user_word1(user_word1), .user_word2(user_word2),
    .pn_long_rst(pn_long_rst), .pn_short_rst(pn_short_rst),
    .smp_valid(smp_valid), .smp_in(smp_in),
    .smp_out(smp_out), .smp_out_vld(smp_out_vld)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [13:0] exp_q[$];
  string       tag_q[$];

  // reference state
  logic [3:0]  m_prev;
  logic [1:0]  u_prev;
  bit          ph;
  int          wk;
  int          cn;
  logic [22:0] pnl;
  logic [22:0] pns;
  logic [13:0] last_out;

  task automatic check(input bit ok, input string req, input logic [13:0] act, input logic [13:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pn_run(inout logic [22:0] s, input int len, input int tap, output logic [13:0] w);
    logic [22:0] mask;
    mask = (23'd1 << len) - 23'd1;
    if (len == 23) mask = '1;
    for (int i = 0; i < 14; i++) begin
      logic b;
      b = s[len-1] ^ s[tap-1];
      w[13-i] = b;
      s = ((s << 1) | 23'(b)) & mask;
    end
  endtask

  task automatic model_reset();
    m_prev = 4'd0; u_prev = 2'd0; ph = 0; wk = 0; cn = 0;
    pnl = 23'h7FFFFF; pns = 23'h1FF;
  endtask

  // One driven cycle; pushes the expected word when the sample is valid.
  task automatic cycle(input logic [3:0] md, input logic [1:0] um, input logic [13:0] din,
                       input bit vld, input bit rl, input bit rs, input string tag);
    logic [13:0] e, wl, ws;
    logic [22:0] tl, ts;
    @(negedge clk);
    mode_code = md; user_mode = um; smp_in = din; smp_valid = vld;
    pn_long_rst = rl; pn_short_rst = rs;
    if (md != m_prev || um != u_prev) begin
      ph = 0; wk = 0; cn = 0; pnl = 23'h7FFFFF; pns = 23'h1FF;
    end
    if (rl) pnl = 23'h7FFFFF;
    if (rs) pns = 23'h1FF;
    if (vld) begin
      tl = pnl; ts = pns;
      pn_run(tl, 23, 18, wl);
      pn_run(ts, 9, 5, ws);
      case (md)
        4'd0:  e = din;
        4'd1:  e = 14'h2000;
        4'd2:  e = 14'h3FFF;
        4'd3:  e = 14'h0000;
        4'd4:  e = ph ? 14'h1555 : 14'h2AAA;
        4'd5:  e = wl;
        4'd6:  e = ws;
        4'd7:  e = ph ? 14'h0000 : 14'h3FFF;
        4'd8: begin
          case (um)
            2'd0: e = user_word1;
            2'd1: e = ph ? user_word2 : user_word1;
            2'd2: e = (cn == 0) ? user_word1 : 14'h0;
            default: e = (cn == 0) ? user_word1 : (cn == 1) ? user_word2 : 14'h0;
          endcase
        end
        4'd9:  e = ph ? 14'h0000 : 14'h0001;
        4'd10: e = (cn == 0) ? 14'h3FFF : 14'h0000;
        4'd11: e = 14'd1 << wk;
        default: e = 14'h0000;
      endcase
      exp_q.push_back(e);
      tag_q.push_back(tag);
      ph = !ph;
      wk = (wk == 13) ? 0 : wk + 1;
      if (cn < 2) cn++;
      if (md == 4'd5) pnl = tl;
      if (md == 4'd6) pns = ts;
    end
    m_prev = md; u_prev = um;
  endtask

  task automatic run(input logic [3:0] md, input logic [1:0] um, input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(md, um, 14'(i * 37 + 5), 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input logic [3:0] md, input logic [1:0] um, input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(md, um, 14'h1ABC, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: pops the scoreboard on valid outputs, checks hold on idle ones
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (smp_out_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 (unexpected valid)", smp_out, 14'h0);
        end else begin
          logic [13:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(smp_out === e, t, smp_out, e);
        end
      end else begin
        check(smp_out === last_out, "R2 (hold on idle)", smp_out, last_out);
      end
      last_out = smp_out;
    end
  end

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    mode_code = 4'd0; user_mode = 2'd0; user_word1 = 14'h0C35; user_word2 = 14'h3A5A;
    pn_long_rst = 0; pn_short_rst = 0; smp_valid = 0; smp_in = 14'h2FFF;
    model_reset();
    last_out = 14'h0;
    repeat (3) @(negedge clk);
    check(smp_out === 14'h0, "R1 (out)", smp_out, 14'h0);
    check(14'(smp_out_vld) === 14'h0, "R1 (vld)", 14'(smp_out_vld), 14'h0);
    smp_valid = 1'b1;
    @(negedge clk);
    check(smp_out === 14'h0, "R1 (out, valid during reset)", smp_out, 14'h0);
    smp_valid = 1'b0;
    rst_n = 1'b1;

    // R3 pass-through with idle gaps (R2)
    cycle(4'd0, 2'd0, 14'h1234, 1, 0, 0, "R3 passthrough");
    idle(4'd0, 2'd0, 2, "R2");
    cycle(4'd0, 2'd0, 14'h3FFE, 1, 0, 0, "R3 passthrough");
    cycle(4'd0, 2'd0, 14'h0001, 1, 0, 0, "R3 passthrough");
    run(4'd1, 2'd0, 2, "R3 midscale");
    run(4'd2, 2'd0, 2, "R3 +FS");
    run(4'd3, 2'd0, 2, "R3 -FS");

    // R4
    run(4'd4, 2'd0, 3, "R4 checkerboard");
    idle(4'd4, 2'd0, 2, "R4");
    run(4'd4, 2'd0, 2, "R4 checkerboard");
    run(4'd7, 2'd0, 3, "R4 word toggle");

    // R5
    run(4'd9, 2'd0, 3, "R5 bit toggle");
    run(4'd11, 2'd0, 10, "R5 walking bit");
    idle(4'd11, 2'd0, 1, "R5");
    run(4'd11, 2'd0, 8, "R5 walking bit wrap");

    // R6
    run(4'd10, 2'd0, 1, "R6 sync");
    idle(4'd10, 2'd0, 1, "R6");
    run(4'd10, 2'd0, 3, "R6 sync after");

    // R7 user patterns
    run(4'd8, 2'd0, 3, "R7 single");
    run(4'd8, 2'd1, 4, "R7 alternate");
    run(4'd8, 2'd2, 3, "R7 single once");
    run(4'd8, 2'd3, 4, "R7 alternate once");
    // R11: rewrite user mode, once pattern restarts
    run(4'd8, 2'd1, 1, "R11 user mode change");
    run(4'd8, 2'd3, 3, "R11 once restart");

    // R8, R9
    run(4'd6, 2'd0, 20, "R8 PN9");
    run(4'd5, 2'd0, 20, "R9 PN23");

    // R10 reload controls
    cycle(4'd5, 2'd0, 14'h0, 1, 1, 0, "R10 long reload with sample");
    run(4'd5, 2'd0, 3, "R10 after long reload");
    cycle(4'd5, 2'd0, 14'h0, 1, 0, 1, "R10 short reload leaves long");
    run(4'd5, 2'd0, 2, "R10 long continues");
    run(4'd6, 2'd0, 4, "R10 PN9 start");
    cycle(4'd6, 2'd0, 14'h0, 0, 0, 1, "R10 short reload idle");
    run(4'd6, 2'd0, 2, "R10 PN9 reseeded");
    cycle(4'd6, 2'd0, 14'h0, 1, 1, 0, "R10 long reload leaves short");
    run(4'd6, 2'd0, 2, "R10 PN9 continues");

    // R11 mode change restarts
    run(4'd4, 2'd0, 3, "R11 checker");
    run(4'd7, 2'd0, 1, "R11 switch");
    run(4'd4, 2'd0, 2, "R11 checker restarted");
    run(4'd11, 2'd0, 5, "R11 walk");
    idle(4'd9, 2'd0, 1, "R11");
    run(4'd11, 2'd0, 2, "R11 walk restarted");

    // R12 reserved codes
    for (int c = 12; c < 16; c++) begin
      cycle(4'(c), 2'd0, 14'h2222, 1, 0, 0, "R12 reserved");
    end
    idle(4'd0, 2'd0, 3, "R2 drain");
    @(negedge clk);
    check(14'(exp_q.size()) === 14'h0, "R2 (all samples produced)", 14'(exp_q.size()), 14'h0);
    finish_up();
  end
endmodule